// File: doc/BRIEF.md
# Reset Exit Sequencer with Start-Address Fetch

This block takes a small 8-bit processor core out of reset. It watches three reset sources: the chip power-on reset, an external active-low reset pin, and a flag that says the core is in stop mode. From these it decides whether the oscillator needs time to settle. When it does, the block runs a stabilization wait. The wait is timed by a free-running clock-division counter that is cleared when the wait begins. The length of the wait comes from a 2-bit option input.

After the wait, and once the external pin is released, the block reads three bytes from a byte-wide ROM port with one cycle of read latency. The first is a mode byte at 0xFFFD. The next two are the start address, high byte at 0xFFFE and low byte at 0xFFFF. The block then gives the core a program-counter load value together with a one-cycle load strobe, and it raises the run enable. A mode byte other than the single-chip value 0x00 sets a sticky error flag. The sequence still completes.

The ROM port is a fixed-latency read strobe and is not valid/ready. The sequencer issues an address with `rom_rd` high. It takes `rom_data` on the next cycle. The port has no back-pressure, so the ROM must always answer one cycle later. The external pin and the stop flag are taken to be synchronous to `clk`. The `phase` output codes are: 0 wait, 1 hold, 2 mode fetch, 3 high fetch, 4 low fetch, 5 load, 6 run.

Top module: `reset_vector_seq`

## Requirements
- R1: The fetch issues `rom_rd` with `rom_addr` 0xFFFD in phase 2, then 0xFFFE in phase 3, then 0xFFFF in phase 4, on consecutive cycles. In phase 5 `rom_rd` is low.
- R2: The cycle after phase 5, the phase is 6. In that cycle `cpu_run` is 1, `cpu_pc_load` is 1 and `cpu_pc` equals {byte at 0xFFFE, byte at 0xFFFF}. From the next cycle on, `cpu_pc_load` is 0 and `cpu_run` stays 1.
- R3: A mode byte that is not 0x00 sets `mode_err`. The flag stays set through later external resets, even when a later mode byte is 0x00. Only `por_n` clears it. A 0x00 mode byte leaves the flag clear.
- R4: After `por_n` is released, the phase stays 0 for W cycles, where W = 2^(BASE_LOG2 + STEP_LOG2*wait_sel), and 2^10, 2^12, 2^14 or 2^16 with the defaults.
- R5: If `ext_rst_n` goes low outside phases 0 and 1 while `stop_mode` is 1, the phase becomes 0 on the next cycle. The counter is cleared at that point, and the phase stays 0 for W further cycles.
- R6: If `ext_rst_n` goes low outside phases 0 and 1 while `stop_mode` is 0, there is no wait. The phase becomes 1, and the phase is 2 on the cycle after the pin is released.
- R7: If the pin is still low when the wait ends, the phase stays 1 until the pin goes high. The phase then moves to 2.
- R8: One cycle after `ext_rst_n` is seen low, `cpu_run` is 0.
- R9: While `por_n` is low, the phase is 0, and `cpu_run`, `cpu_pc_load`, `rom_rd` and `mode_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| stop_mode | input | 1 | Core is in stop mode |
| wait_sel | input | SEL_W | Stabilization wait option |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | 16 | ROM read address |
| rom_data | input | 8 | ROM data, valid one cycle after the strobe |
| cpu_pc | output | 16 | Start address for the core |
| cpu_pc_load | output | 1 | One-cycle program-counter load strobe |
| cpu_run | output | 1 | Core run enable |
| mode_err | output | 1 | Sticky bad-mode flag |
| phase | output | 3 | Current phase code |

## Verification
The bench sweeps every wait option after power-on and after a stop-mode external reset, and counts the cycles spent in phase 0. An off-by-one terminal count, or a counter that is not cleared on entry, would show up as a wrong cycle count. A non-stop external reset must skip the wait; a design that always waited would stall there for many cycles. The bench holds the pin low past the end of the wait to catch a design that starts the fetch early. It also swaps the start-address bytes between runs, so a byte-order or latency error gives a wrong `cpu_pc`. Finally it reruns the fetch with a good mode byte after a bad one, to catch a mode flag that is not sticky.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  typedef enum logic [2:0] {
    PH_OSC  = 3'd0,
    PH_HOLD = 3'd1,
    PH_MODE = 3'd2,
    PH_HI   = 3'd3,
    PH_LO   = 3'd4,
    PH_LOAD = 3'd5,
    PH_RUN  = 3'd6
  } phase_e;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 16'hFFFD;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 16'hFFFE;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 16'hFFFF;
  localparam logic [DATA_W-1:0] MODE_SINGLE = 8'h00;
endpackage

// File: rtl/rvs_timebase.sv
module rvs_timebase #(
  parameter int BASE_LOG2 = 10,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clear,
  input  logic [SEL_W-1:0] wait_sel,
  output logic             expired
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);

  logic [CNT_W-1:0] tb_cnt;
  logic [CNT_W-1:0] term [NSEL];

  // free-running division counter, shared time base
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     tb_cnt <= '0;
    else if (clear) tb_cnt <= '0;
    else            tb_cnt <= tb_cnt + 1'b1;
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_term
    localparam int LG = BASE_LOG2 + STEP_LOG2 * g;
    assign term[g] = CNT_W'((64'd1 << LG) - 64'd1);
  end

  assign expired = (tb_cnt == term[wait_sel]);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    clear |=> (tb_cnt == '0)) else $error("clear"); // R5
endmodule

// File: rtl/rvs_fetch.sv
module rvs_fetch
  import rvs_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              cap_mode,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic [DATA_W-1:0] rom_data,
  output logic              mode_err,
  output logic [ADDR_W-1:0] pc,
  output logic              pc_load
);
  logic [DATA_W-1:0] hi_byte;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_err <= 1'b0;
      hi_byte  <= '0;
      pc       <= '0;
      pc_load  <= 1'b0;
    end else begin
      pc_load <= cap_lo;
      if (cap_mode && (rom_data != MODE_SINGLE)) mode_err <= 1'b1;
      if (cap_hi) hi_byte <= rom_data;
      if (cap_lo) pc <= {hi_byte, rom_data};
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    mode_err |=> mode_err) else $error("err"); // R3
endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq
  import rvs_pkg::*;
#(
  parameter int BASE_LOG2 = 10,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              stop_mode,
  input  logic [SEL_W-1:0]  wait_sel,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic [ADDR_W-1:0] cpu_pc,
  output logic              cpu_pc_load,
  output logic              cpu_run,
  output logic              mode_err,
  output logic [2:0]        phase
);
  phase_e state, nxt;
  logic   clr_tb, expired, abort;

  rvs_timebase #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .SEL_W(SEL_W)) u_tb (
    .clk(clk), .por_n(por_n), .clear(clr_tb), .wait_sel(wait_sel), .expired(expired)
  );

  assign abort = !ext_rst_n && (state != PH_OSC) && (state != PH_HOLD);

  always_comb begin
    nxt    = state;
    clr_tb = 1'b0;
    if (abort) begin
      if (stop_mode) begin
        nxt    = PH_OSC;
        clr_tb = 1'b1;
      end else begin
        nxt = PH_HOLD;
      end
    end else begin
      case (state)
        PH_OSC:  if (expired) nxt = ext_rst_n ? PH_MODE : PH_HOLD;
        PH_HOLD: if (ext_rst_n) nxt = PH_MODE;
        PH_MODE: nxt = PH_HI;
        PH_HI:   nxt = PH_LO;
        PH_LO:   nxt = PH_LOAD;
        PH_LOAD: nxt = PH_RUN;
        default: nxt = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state <= PH_OSC;
    else        state <= nxt;
  end

  always_comb begin
    rom_rd   = 1'b1;
    rom_addr = ADDR_MODE;
    case (state)
      PH_MODE: rom_addr = ADDR_MODE;
      PH_HI:   rom_addr = ADDR_HI;
      PH_LO:   rom_addr = ADDR_LO;
      default: begin rom_rd = 1'b0; rom_addr = '0; end
    endcase
  end

  rvs_fetch u_fetch (
    .clk(clk), .por_n(por_n),
    .cap_mode((state == PH_HI) && ext_rst_n),
    .cap_hi((state == PH_LO) && ext_rst_n),
    .cap_lo((state == PH_LOAD) && ext_rst_n),
    .rom_data(rom_data), .mode_err(mode_err),
    .pc(cpu_pc), .pc_load(cpu_pc_load)
  );

  assign cpu_run = (state == PH_RUN);
  assign phase   = state;

  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!por_n)
    (state == PH_MODE && ext_rst_n) |=> (state == PH_HI)) else $error("order"); // R1
  AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!por_n)
    rom_rd |-> (rom_addr >= ADDR_MODE)) else $error("addr"); // R1
  AST_LOAD_RUN: assert property (@(posedge clk) disable iff (!por_n)
    cpu_pc_load |-> cpu_run) else $error("load"); // R2
  AST_NOSTOP_SKIP: assert property (@(posedge clk) disable iff (!por_n)
    (!ext_rst_n && !stop_mode && state == PH_RUN) |=> (state == PH_HOLD)) else $error("skip"); // R6
  AST_HOLD_PIN: assert property (@(posedge clk) disable iff (!por_n)
    (state == PH_HOLD && !ext_rst_n) |=> (state == PH_HOLD)) else $error("hold"); // R7
  AST_RUN_DROP: assert property (@(posedge clk) disable iff (!por_n)
    !ext_rst_n |=> !cpu_run) else $error("run"); // R8
endmodule

// File: tb/reset_vector_seq_bench.sv
module reset_vector_seq_bench;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        ext_rst_n = 1'b1;
  logic        stop_mode = 1'b0;
  logic [1:0]  wait_sel = 2'd0;
  logic        rom_rd;
  logic [15:0] rom_addr;
  logic [7:0]  rom_data = 8'h00;
  logic [15:0] cpu_pc;
  logic        cpu_pc_load, cpu_run, mode_err;
  logic [2:0]  phase;
  logic [7:0]  rom_mode = 8'h00, rom_hi = 8'h00, rom_lo = 8'h00;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  reset_vector_seq #(.BASE_LOG2(2), .STEP_LOG2(2), .SEL_W(2)) u_reset_vector_seq (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .stop_mode(stop_mode),
    .wait_sel(wait_sel), .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .cpu_pc(cpu_pc), .cpu_pc_load(cpu_pc_load), .cpu_run(cpu_run),
    .mode_err(mode_err), .phase(phase)
  );

  always @(posedge clk)
    if (rom_rd)
      case (rom_addr)
        16'hFFFD: rom_data <= rom_mode;
        16'hFFFE: rom_data <= rom_hi;
        16'hFFFF: rom_data <= rom_lo;
        default:  rom_data <= 8'hEE;
      endcase

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wlen(input int sel);
    return 1 << (2 + 2 * sel);
  endfunction

  // starts at a negedge where phase 2 is expected
  task automatic check_fetch(input logic [15:0] exp_pc, input logic exp_err);
    chk(phase == 3'd2 && rom_rd && rom_addr == 16'hFFFD, "R1 mode", {13'd0, phase}, 32'h2);
    @(negedge clk);
    chk(phase == 3'd3 && rom_rd && rom_addr == 16'hFFFE, "R1 hi", {13'd0, phase}, 32'h3);
    @(negedge clk);
    chk(phase == 3'd4 && rom_rd && rom_addr == 16'hFFFF, "R1 lo", {13'd0, phase}, 32'h4);
    @(negedge clk);
    chk(phase == 3'd5 && !rom_rd, "R1 load", {13'd0, phase}, 32'h5);
    @(negedge clk);
    chk(phase == 3'd6 && cpu_run && cpu_pc_load && cpu_pc == exp_pc, "R2 pc", cpu_pc, exp_pc);
    chk(mode_err == exp_err, "R3 err", mode_err, exp_err);
    @(negedge clk);
    chk(cpu_run && !cpu_pc_load && cpu_pc == exp_pc, "R2 steady", cpu_pc_load, 0);
  endtask

  task automatic count_osc(output int n);
    n = 0;
    while (phase == 3'd0 && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_por(input int sel);
    int n;
    @(negedge clk);
    por_n = 1'b0;
    wait_sel = 2'(sel);
    @(negedge clk);
    chk(phase == 3'd0 && !cpu_run && !rom_rd && !mode_err && !cpu_pc_load,
        "R9 reset", {13'd0, phase}, 0);
    por_n = 1'b1;
    @(negedge clk);
    count_osc(n);
    chk(n == wlen(sel) - 1, "R4 por wait", n, wlen(sel) - 1);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R4: every option after power-on
    for (int s = 0; s < 4; s++) begin
      rom_mode = 8'h00;
      rom_hi = 8'h10 + 8'(s);
      rom_lo = 8'h3C ^ 8'(s);
      do_por(s);
      check_fetch({rom_hi, rom_lo}, 1'b0);
    end
    // R3: bad mode byte, then a good one after an external reset
    rom_mode = 8'h5A; rom_hi = 8'hA5; rom_lo = 8'h01;
    do_por(0);
    check_fetch(16'hA501, 1'b1);
    rom_mode = 8'h00; rom_hi = 8'h01; rom_lo = 8'hA5;
    ext_rst_n = 1'b0; stop_mode = 1'b0;
    @(negedge clk);
    chk(phase == 3'd1 && !cpu_run, "R6 R8 hold no wait", {13'd0, phase}, 1);
    repeat (3) @(negedge clk);
    chk(phase == 3'd1, "R6 hold", {13'd0, phase}, 1);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check_fetch(16'h01A5, 1'b1);
    // R9: power-on clears the flag
    do_por(1);
    check_fetch(16'h01A5, 1'b0);
    // R5: stop-mode external reset, every option, pin released early
    for (int s = 0; s < 4; s++) begin
      wait_sel = 2'(s);
      rom_hi = 8'hC0 | 8'(s); rom_lo = 8'h7F - 8'(s);
      ext_rst_n = 1'b0; stop_mode = 1'b1;
      @(negedge clk);
      chk(phase == 3'd0 && !cpu_run, "R8 R5 enter wait", {13'd0, phase}, 0);
      ext_rst_n = 1'b1; stop_mode = 1'b0;
      count_osc(n);
      chk(n == wlen(s), "R5 stop wait", n, wlen(s));
      check_fetch({rom_hi, rom_lo}, 1'b0);
    end
    // R7: pin held past the end of the wait
    wait_sel = 2'd1;
    ext_rst_n = 1'b0; stop_mode = 1'b1;
    @(negedge clk);
    stop_mode = 1'b0;
    count_osc(n);
    chk(n == wlen(1), "R7 wait len", n, wlen(1));
    for (int k = 0; k < 4; k++) begin
      chk(phase == 3'd1 && !rom_rd, "R7 held", {13'd0, phase}, 1);
      @(negedge clk);
    end
    ext_rst_n = 1'b1;
    @(negedge clk);
    check_fetch({rom_hi, rom_lo}, 1'b0);
    // R7: pin low across power-on release
    @(negedge clk);
    por_n = 1'b0; ext_rst_n = 1'b0; wait_sel = 2'd0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    count_osc(n);
    chk(n == wlen(0) - 1 && phase == 3'd1, "R7 por hold", n, wlen(0) - 1);
    repeat (2) @(negedge clk);
    chk(phase == 3'd1, "R7 por held", {13'd0, phase}, 1);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check_fetch({rom_hi, rom_lo}, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule